// File: doc/BRIEF.md
# Chip Erase Sequencer

This block sits between a flash command bus and a memory-array model and handles whole-array erase. It watches bus writes for a six-write unlock-and-confirm sequence. Once the sequence completes it walks the array one block at a time, sending an erase request to each block whose protect bit was set clear when the sequence finished. Protected blocks are passed over without complaint.

While the walk runs, the block accepts no command of any kind, so the operation cannot be suspended or aborted. Every bus read returns a status byte in place of array data. If every block is protected, the block still goes busy for a fixed, parameterised number of cycles and then returns with nothing erased. A failed block erase stops the walk. The status byte then stays on the read path until software writes a read/reset command. In the idle read mode, reads pass the array data straight through.

Top module: `ce_chip_erase`

## Requirements
- R1: The erase starts only after six consecutive bus writes with data/address (compared on address bits 10:0) AAh/555h, 55h/2AAh, 80h/555h, AAh/555h, 55h/2AAh, 10h/555h. `busy` is high in the clock cycle after the sixth write.
- R2: A write whose address or data does not match the step it lands on sends the decoder back to step one. A complete, fresh six-write sequence is then needed to start.
- R3: Erase requests go to blocks in ascending index order. At most one bit of `erase_req` is high at any time. A request is held until `erase_done` is seen, and at least one idle cycle separates consecutive requests.
- R4: The protect vector is captured when the sequence completes. A block whose captured protect bit is 1 receives no request, and skipping it raises no error.
- R5: If every block is protected, `busy` stays high for exactly FAKE_CYC cycles, no request is issued, and the block then returns to read mode.
- R6: While `busy` is high, every write is ignored, including a F0h read/reset, a B0h suspend and a complete new erase sequence. The walk runs to its end.
- R7: A read while `busy` is high returns the status byte. Bit 7 is 0, bit 5 is 0, bits 4..0 are 0, and bit 6 is 0 on the first read after the start and inverts on every further status read.
- R8: After the last block completes without failure, `busy` falls and reads return `arr_data`.
- R9: When `erase_done` comes with `erase_fail` high, no further request is issued and `busy` falls. Reads then return status with bit 5 = 1, bit 7 = 0 and bit 6 still toggling. This state ignores every write except data F0h at any address, which returns the block to read mode.
- R10: After reset, `busy` is 0, `erase_req` is all zero and reads return `arr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Bus write data |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| arr_data | input | 8 | Data from the array model at `addr` |
| rd_data | output | 8 | Read data: array data or status byte |
| prot | input | NBLK | Per-block protect bits |
| erase_req | output | NBLK | One-hot erase request to the array model |
| erase_done | input | 1 | Array model finished the requested block |
| erase_fail | input | 1 | Qualifies `erase_done` as a failure |
| busy | output | 1 | Erase walk or the all-protected busy period in progress |

## Verification
The sixth write is registered at one clock edge, so `busy` is sampled at the falling edge right after the write strobe drops. The bench's array model raises `erase_done` a fixed LAT falling edges into each request and logs the block index there. The request order is therefore compared after `busy` falls, not cycle by cycle. `rd_data` is combinational from registered state and is sampled 1 ns after the read strobe is driven on a falling edge, before the edge at which the toggle bit inverts. The all-protected busy period is measured by counting falling edges with `busy` high and comparing the count with FAKE_CYC.

// File: rtl/ce_pkg.sv
// Shared types for the chip erase sequencer.
package ce_pkg;
    // Walk controller states
    typedef enum logic [2:0] {
        W_IDLE,   // read-array mode, decoder listening
        W_SCAN,   // inspect captured protect bit of current block
        W_WAIT,   // request outstanding for current block
        W_FAKE,   // all blocks protected: timed dummy busy period
        W_ERR     // failed erase, status latched until read/reset
    } walk_st_t;

    localparam int CMD_AW = 11;  // address bits compared by the decoder
endpackage

// File: rtl/ce_cmd_decoder.sv
// Command decoder: recognises the six-write chip-erase sequence.
// Assumes one write per strobe cycle; en low holds it at step one.
module ce_cmd_decoder #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              start
);
    import ce_pkg::*;

    logic [2:0]        step;
    logic [CMD_AW-1:0] exp_addr;
    logic [7:0]        exp_data;
    logic              hit;

    // Expected address/data for the current step
    always_comb begin
        case (step)
            3'd0:    begin exp_addr = 11'h555; exp_data = 8'hAA; end
            3'd1:    begin exp_addr = 11'h2AA; exp_data = 8'h55; end
            3'd2:    begin exp_addr = 11'h555; exp_data = 8'h80; end
            3'd3:    begin exp_addr = 11'h555; exp_data = 8'hAA; end
            3'd4:    begin exp_addr = 11'h2AA; exp_data = 8'h55; end
            default: begin exp_addr = 11'h555; exp_data = 8'h10; end
        endcase
    end

    assign hit   = en && wr_en && (addr[CMD_AW-1:0] == exp_addr) && (wdata == exp_data);
    assign start = hit && (step == 3'd5);

    // Step counter: advance on a match, fall back to step one otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            step <= 3'd0;
        end else if (wr_en) begin
            if (hit && step != 3'd5) step <= step + 3'd1;
            else                     step <= 3'd0;
        end
    end
endmodule

// File: rtl/ce_block_walker.sv
// Block walker: erases unprotected blocks one by one in ascending order.
// Assumes erase_done is a single-cycle pulse answering the held request.
module ce_block_walker #(
    parameter int NBLK     = 8,
    parameter int FAKE_CYC = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            clr,
    input  logic [NBLK-1:0] prot,
    input  logic            erase_done,
    input  logic            erase_fail,
    output logic [NBLK-1:0] erase_req,
    output logic [NBLK-1:0] prot_snap,
    output logic            busy,
    output logic            err,
    output logic            idle
);
    import ce_pkg::*;

    localparam int IDX_W = (NBLK > 1) ? $clog2(NBLK) : 1;
    localparam int FCW   = $clog2(FAKE_CYC + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NBLK - 1);

    walk_st_t       st;
    logic [IDX_W-1:0] idx;
    logic [FCW-1:0]   cnt;

    // Walk state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= W_IDLE;
            idx       <= '0;
            cnt       <= '0;
            prot_snap <= '0;
        end else begin
            case (st)
                W_IDLE: if (start) begin
                    prot_snap <= prot;
                    idx       <= '0;
                    if (&prot) begin
                        st  <= W_FAKE;
                        cnt <= FCW'(FAKE_CYC - 1);
                    end else begin
                        st <= W_SCAN;
                    end
                end
                W_SCAN: begin
                    if (!prot_snap[idx])  st <= W_WAIT;
                    else if (idx == LAST) st <= W_IDLE;
                    else                  idx <= idx + IDX_W'(1);
                end
                W_WAIT: if (erase_done) begin
                    if (erase_fail) begin
                        st <= W_ERR;
                    end else if (idx == LAST) begin
                        st <= W_IDLE;
                    end else begin
                        idx <= idx + IDX_W'(1);
                        st  <= W_SCAN;
                    end
                end
                W_FAKE: begin
                    if (cnt == '0) st <= W_IDLE;
                    else           cnt <= cnt - FCW'(1);
                end
                W_ERR:   if (clr) st <= W_IDLE;
                default: st <= W_IDLE;
            endcase
        end
    end

    // One request line per block, high only while that block is awaited
    for (genvar b = 0; b < NBLK; b++) begin : g_req
        assign erase_req[b] = (st == W_WAIT) && (idx == IDX_W'(b));
    end

    assign busy = (st == W_SCAN) || (st == W_WAIT) || (st == W_FAKE);
    assign err  = (st == W_ERR);
    assign idle = (st == W_IDLE);
endmodule

// File: rtl/ce_status_reg.sv
// Status byte and read-path select.
// Assumes rd_en is high for one cycle per read; the toggle bit flips per status read.
module ce_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       busy,
    input  logic       err,
    input  logic       rd_en,
    input  logic [7:0] arr_data,
    output logic [7:0] rd_data
);
    logic tog;
    logic show;

    assign show = busy || err;

    // Toggle bit: cleared at start, inverted on each status read
    always_ff @(posedge clk) begin
        if (!rst_n || start) tog <= 1'b0;
        else if (show && rd_en) tog <= ~tog;
    end

    // Read mux: status while busy or in error, array data otherwise
    assign rd_data = show ? {1'b0, tog, err, 5'b0} : arr_data;
endmodule

// File: rtl/ce_chip_erase.sv
// Chip erase sequencer top: command decode, block walk, status read path.
// Assumes array timing is modelled outside by the erase_done/erase_fail handshake.
module ce_chip_erase #(
    parameter int NBLK     = 8,
    parameter int ADDR_W   = 12,
    parameter int FAKE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              rd_en,
    input  logic [7:0]        arr_data,
    output logic [7:0]        rd_data,
    input  logic [NBLK-1:0]   prot,
    output logic [NBLK-1:0]   erase_req,
    input  logic              erase_done,
    input  logic              erase_fail,
    output logic              busy
);
    logic            start;
    logic            err_hold;
    logic            idle;
    logic            clr;
    logic [NBLK-1:0] prot_snap;

    // Read/reset data clears a latched error; other writes there are dropped
    assign clr = err_hold && wr_en && (wdata == 8'hF0);

    ce_cmd_decoder #(.ADDR_W(ADDR_W)) dec_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (idle),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .start (start)
    );

    ce_block_walker #(.NBLK(NBLK), .FAKE_CYC(FAKE_CYC)) walk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .clr        (clr),
        .prot       (prot),
        .erase_done (erase_done),
        .erase_fail (erase_fail),
        .erase_req  (erase_req),
        .prot_snap  (prot_snap),
        .busy       (busy),
        .err        (err_hold),
        .idle       (idle)
    );

    ce_status_reg stat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .err      (err_hold),
        .rd_en    (rd_en),
        .arr_data (arr_data),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/ce_chip_erase_chk.sv
// Protocol checker for ce_chip_erase, attached with bind.
module ce_chip_erase_chk #(
    parameter int NBLK = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            err,
    input logic            wr_en,
    input logic            rd_en,
    input logic [7:0]      rd_data,
    input logic [NBLK-1:0] erase_req,
    input logic [NBLK-1:0] prot_snap,
    input logic            erase_done
);
    p_req_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(erase_req));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(erase_req) != '0 && !$past(erase_done)) |-> erase_req == $past(erase_req));

    p_req_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req != '0) |-> busy);

    p_skip_protected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req & prot_snap) == '0);

    p_no_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && erase_req != '0 && !erase_done) |=> busy);

    p_busy_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |-> (rd_data[7] == 1'b0 && rd_data[5] == 1'b0 && rd_data[4:0] == 5'd0));

    p_status_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy || err) && $past(rd_en) && (busy || err) && rd_en)
            |-> rd_data[6] != $past(rd_data[6]));

    p_error_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && rd_en) |-> (rd_data[5] && !rd_data[7]));

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && erase_req == '0));
endmodule

bind ce_chip_erase ce_chip_erase_chk #(.NBLK(NBLK)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .err        (err_hold),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .erase_req  (erase_req),
    .prot_snap  (prot_snap),
    .erase_done (erase_done)
);

// File: tb/ce_chip_erase_tb_top.sv
// Bench: sweeps every protect pattern of a 4-block array, then error and command-ignore cases.
module ce_chip_erase_tb_top;
    localparam int  NBLK     = 4;
    localparam int  ADDR_W   = 12;
    localparam int  FAKE_CYC = 12;
    localparam int  LAT      = 6;
    localparam time T_CLK    = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic              rd_en = 1'b0;
    logic [7:0]        arr_data;
    logic [7:0]        rd_data;
    logic [NBLK-1:0]   prot = '0;
    logic [NBLK-1:0]   erase_req;
    logic              erase_done = 1'b0;
    logic              erase_fail = 1'b0;
    logic              busy;

    int tests = 0;
    int fails = 0;
    int log_blk [16];
    int log_n = 0;
    int fail_blk = -1;
    int lat_cnt = 0;

    always #(T_CLK / 2) clk = ~clk;

    assign arr_data = addr[7:0] ^ 8'h3C;

    ce_chip_erase #(.NBLK(NBLK), .ADDR_W(ADDR_W), .FAKE_CYC(FAKE_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .arr_data(arr_data), .rd_data(rd_data), .prot(prot),
        .erase_req(erase_req), .erase_done(erase_done), .erase_fail(erase_fail),
        .busy(busy)
    );

    // Array model: answers a held request LAT falling edges later and logs the block
    always @(negedge clk) begin
        if (erase_req != '0 && !erase_done) begin
            lat_cnt = lat_cnt + 1;
            if (lat_cnt == LAT) begin
                for (int b = 0; b < NBLK; b++) begin
                    if (erase_req[b]) begin
                        if (log_n < 16) log_blk[log_n] = b;
                        log_n = log_n + 1;
                        erase_fail = (b == fail_blk);
                    end
                end
                erase_done = 1'b1;
            end
        end else begin
            erase_done = 1'b0;
            erase_fail = 1'b0;
            lat_cnt = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic erase_seq();
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h10);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk(busy == 1'b0, "R10 busy", busy, 0);
        chk(erase_req == '0, "R10 erase_req", erase_req, 0);
        rd(12'h012, v);
        chk(v == (8'h12 ^ 8'h3C), "R10 read path", v, 8'h12 ^ 8'h3C);

        // R2: broken sequences do not start
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
        wr(12'h555, 8'h80); wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h10);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R2 wrong data mid-sequence", busy, 0);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h554, 8'h10);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R2 wrong address on last write", busy, 0);
        chk(log_n == 0, "R2 no request", log_n, 0);

        // R1/R3/R4/R5/R8: sweep all protect patterns
        for (int p = 0; p < (1 << NBLK); p++) begin
            prot = NBLK'(p);
            log_n = 0;
            erase_seq();
            chk(busy == 1'b1, "R1 busy after sixth write", busy, 1);
            wait_idle(n);
            if (p == (1 << NBLK) - 1) begin
                chk(n == FAKE_CYC, "R5 all-protected busy length", n, FAKE_CYC);
                chk(log_n == 0, "R5 no request", log_n, 0);
            end else begin
                k = 0;
                for (int b = 0; b < NBLK; b++) begin
                    if (!p[b]) begin
                        chk(k < log_n && log_blk[k] == b, "R3/R4 request order", log_blk[k], b);
                        k++;
                    end
                end
                chk(log_n == k, "R4 request count", log_n, k);
            end
            rd(12'h0A5, v);
            chk(v == (8'hA5 ^ 8'h3C), "R8 read array after completion", v, 8'hA5 ^ 8'h3C);
        end

        // R7/R6: status reads while busy, then ignored commands
        prot = '0;
        log_n = 0;
        erase_seq();
        for (int r = 0; r < 4; r++) begin
            rd(12'h100, v);
            chk(v == ((r % 2) ? 8'h40 : 8'h00), "R7 status byte", v, (r % 2) ? 8'h40 : 8'h00);
        end
        wr(12'h000, 8'hF0);
        wr(12'h555, 8'hB0);
        erase_seq();
        chk(busy == 1'b1, "R6 busy after ignored commands", busy, 1);
        wait_idle(n);
        chk(log_n == NBLK, "R6 walk completed", log_n, NBLK);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R6 ignored sequence did not restart", busy, 0);

        // R9: failure on block 2 with block 1 protected
        prot = 4'b0010;
        fail_blk = 2;
        log_n = 0;
        erase_seq();
        wait_idle(n);
        repeat (LAT + 4) @(negedge clk);
        chk(log_n == 2 && log_blk[1] == 2, "R9 stop after failing block", log_n, 2);
        chk(busy == 1'b0, "R9 busy low in error", busy, 0);
        rd(12'h033, v);
        chk(v == 8'h20, "R9 error status first read", v, 8'h20);
        rd(12'h033, v);
        chk(v == 8'h60, "R9 error status toggles", v, 8'h60);
        wr(12'h555, 8'hAA);
        rd(12'h033, v);
        chk(v == 8'h20, "R9 other write ignored", v, 8'h20);
        wr(12'h7FF, 8'hF0);
        rd(12'h033, v);
        chk(v == (8'h33 ^ 8'h3C), "R9 read/reset returns to array", v, 8'h33 ^ 8'h3C);
        fail_blk = -1;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule